// File: doc/BRIEF.md
# Debug Address Match Unit

This block holds a small bank of address comparison slots for a processor debug facility. Each slot is either a breakpoint, which compares the program counter of the instruction sitting in the decode stage, or a watchpoint, which compares the address of a data access and can be limited to reads, writes or both. When any armed slot matches the current cycle's activity, the block raises a halt request in that same cycle and reports the number of the slot. The surrounding debug logic can then freeze the pipeline before the instruction or the access takes effect.

Slots are programmed from the debug command byte stream. After the stream parser has decoded a command that selects this unit, it forwards the following bytes on the configuration port. The first byte is a packed control byte. If that byte enables a slot, four address bytes follow it. If it disables a slot, nothing follows. The number of slots is a build-time parameter, intended to be 2, 4 or 8.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset every slot is disarmed, and no decode PC or data access raises `hit`, address zero included. While no slot matches, `hit_slot` reads 0.
- R2: The control byte carries these fields. Bits 3:0 hold the slot number. Bit 4 is the kind: 1 selects a watchpoint and 0 a breakpoint. Bit 5 is enable. Bits 7:6 hold the watchpoint access filter.
- R3: When a control byte has enable set, the next four bytes accepted with `cfg_valid` form the 32-bit address, most significant byte first. Cycles with `cfg_valid` low are skipped. The slot keeps its previous setting until the fourth address byte is accepted, and uses the new setting from the following cycle on.
- R4: A control byte with enable clear is a single byte. It disarms the addressed slot from the following cycle on, and the byte after it is read as a new control byte.
- R5: An armed breakpoint slot matches only when `dec_valid` is high and `dec_pc` equals its stored address in all 32 bits. Data accesses never trigger a breakpoint.
- R6: An armed watchpoint slot matches only on a data access whose `mem_addr` equals its stored address in all 32 bits. Filter 00 matches writes (`mem_wr`), 01 matches reads (`mem_rd`), and 11 matches either. The decode PC never triggers a watchpoint.
- R7: A watchpoint slot programmed with access filter 10 never matches.
- R8: A control byte whose slot number is equal to or greater than the slot count changes no slot. If its enable bit is set, its four address bytes are still consumed.
- R9: When several slots match in the same cycle, `hit_slot` reports the lowest-numbered of them.
- R10: `hit` and `hit_slot` follow the decode and access inputs combinationally, in the same cycle, with no register between the inputs and these outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_byte | input | 8 | Configuration byte from the debug command stream |
| cfg_valid | input | 1 | `cfg_byte` holds a byte this cycle |
| dec_valid | input | 1 | An instruction occupies the decode stage |
| dec_pc | input | 32 | Program counter of the decode-stage instruction |
| mem_rd | input | 1 | A data read is in progress this cycle |
| mem_wr | input | 1 | A data write is in progress this cycle |
| mem_addr | input | 32 | Address of the data access |
| hit | output | 1 | Halt request: an armed slot matches |
| hit_slot | output | $clog2(NUM_SLOTS) | Lowest-numbered matching slot, 0 when there is no match |

## Verification
The hardest case to reach from the ports is a configuration that is only partly received. The bench has to observe a slot while three of its four address bytes have arrived, with idle gaps between them, and show that the slot does not change until the fourth byte. It must also show that an ignored out-of-range control byte still consumes its address bytes. The bench reaches these states by sending the bytes one at a time and probing the decode port between them. After the out-of-range byte, it programs a valid slot and confirms that this slot fires, which is only possible if the parser resynchronised on the correct byte. Priority is driven by vectors in which a decode hit and a data hit, or two watchpoints, match in the same cycle.

// File: rtl/dbg_match_pkg.sv
// Package: shared types for the debug address match unit.
// Assumes 32-bit addresses delivered as four bytes on the configuration port.
package dbg_match_pkg;

    localparam int ADDR_W = 32;

    // Access filter encoding of a watchpoint slot (control byte bits 7:6).
    typedef enum logic [1:0] {
        ACC_WR  = 2'b00,
        ACC_RD  = 2'b01,
        ACC_OFF = 2'b10,
        ACC_ANY = 2'b11
    } acc_e;

    // Stored setting of one slot.
    typedef struct packed {
        logic              armed;
        logic              watch;
        acc_e              acc;
        logic [ADDR_W-1:0] addr;
    } slot_cfg_t;

    localparam slot_cfg_t SLOT_IDLE = '{armed: 1'b0, watch: 1'b0, acc: ACC_WR, addr: '0};

endpackage

// File: rtl/dbg_cfg_parser.sv
// Module: dbg_cfg_parser
// Turns the configuration byte stream into slot write requests.
// Assumes the command opcode has been stripped upstream; the first byte seen
// after reset is a control byte. Out-of-range slot numbers produce no write.
module dbg_cfg_parser
    import dbg_match_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cfg_byte,
    input  logic              cfg_valid,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_idx,
    output slot_cfg_t         wr_cfg
);

    localparam logic [4:0] SLOT_LIMIT = 5'(NUM_SLOTS);

    typedef enum logic {PS_CTRL, PS_ADDR} pstate_e;

    pstate_e     state;
    logic [1:0]  byte_cnt;
    logic [23:0] addr_hi;
    logic [7:0]  ctl_q;

    logic        ctl_in_range;
    logic        held_in_range;

    assign ctl_in_range  = {1'b0, cfg_byte[3:0]} < SLOT_LIMIT;
    assign held_in_range = {1'b0, ctl_q[3:0]} < SLOT_LIMIT;

    // Sequence control byte and address bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PS_CTRL;
            byte_cnt <= '0;
            addr_hi  <= '0;
            ctl_q    <= '0;
        end else if (cfg_valid) begin
            case (state)
                PS_CTRL: begin
                    ctl_q    <= cfg_byte;
                    byte_cnt <= '0;
                    if (cfg_byte[5]) state <= PS_ADDR;
                end
                PS_ADDR: begin
                    addr_hi  <= {addr_hi[15:0], cfg_byte};
                    byte_cnt <= byte_cnt + 2'd1;
                    if (byte_cnt == 2'd3) state <= PS_CTRL;
                end
                default: state <= PS_CTRL;
            endcase
        end
    end

    // Form the slot write for a disable byte or the last address byte.
    always_comb begin
        wr_en  = 1'b0;
        wr_idx = '0;
        wr_cfg = SLOT_IDLE;
        if (cfg_valid && state == PS_CTRL && !cfg_byte[5]) begin
            wr_en  = ctl_in_range;
            wr_idx = cfg_byte[SLOT_W-1:0];
        end else if (cfg_valid && state == PS_ADDR && byte_cnt == 2'd3) begin
            wr_en        = held_in_range;
            wr_idx       = ctl_q[SLOT_W-1:0];
            wr_cfg.armed = 1'b1;
            wr_cfg.watch = ctl_q[4];
            wr_cfg.acc   = acc_e'(ctl_q[7:6]);
            wr_cfg.addr  = {addr_hi, cfg_byte};
        end
    end

endmodule

// File: rtl/dbg_slot_bank.sv
// Module: dbg_slot_bank
// Holds the slot registers and compares each against the current decode PC
// and data access. Produces one match bit per slot; combinational in the inputs.
module dbg_slot_bank
    import dbg_match_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_idx,
    input  slot_cfg_t         wr_cfg,
    input  logic              dec_valid,
    input  logic [ADDR_W-1:0] dec_pc,
    input  logic              mem_rd,
    input  logic              mem_wr,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic [NUM_SLOTS-1:0] match
);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        slot_cfg_t cfg_q;
        logic      acc_ok;

        // Store the slot setting when its write request arrives.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q <= SLOT_IDLE;
            end else if (wr_en && wr_idx == SLOT_W'(s)) begin
                cfg_q <= wr_cfg;
            end
        end

        // Check the data access against the slot's access filter.
        always_comb begin
            case (cfg_q.acc)
                ACC_WR:  acc_ok = mem_wr;
                ACC_RD:  acc_ok = mem_rd;
                ACC_ANY: acc_ok = mem_rd | mem_wr;
                default: acc_ok = 1'b0;
            endcase
        end

        // Compare the selected source against the stored address.
        always_comb begin
            if (!cfg_q.armed) begin
                match[s] = 1'b0;
            end else if (cfg_q.watch) begin
                match[s] = acc_ok && (mem_addr == cfg_q.addr);
            end else begin
                match[s] = dec_valid && (dec_pc == cfg_q.addr);
            end
        end
    end

endmodule

// File: rtl/dbg_prio_pick.sv
// Module: dbg_prio_pick
// Reduces the per-slot match vector to a hit flag and the lowest set index.
// Reports index 0 when no bit is set.
module dbg_prio_pick #(
    parameter int NUM_SLOTS = 4,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic [NUM_SLOTS-1:0] match,
    output logic                 any,
    output logic [SLOT_W-1:0]    idx
);

    // Scan from the top down so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (match[i]) idx = SLOT_W'(i);
        end
    end

    assign any = |match;

endmodule

// File: rtl/dbg_match_unit.sv
// Module: dbg_match_unit (top)
// Debug breakpoint/watchpoint slots programmed from a byte stream; raises a
// same-cycle halt request with the lowest matching slot number.
// Assumes synchronous active-low reset and 2..8 slots.
module dbg_match_unit
    import dbg_match_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cfg_byte,
    input  logic              cfg_valid,
    input  logic              dec_valid,
    input  logic [31:0]       dec_pc,
    input  logic              mem_rd,
    input  logic              mem_wr,
    input  logic [31:0]       mem_addr,
    output logic              hit,
    output logic [SLOT_W-1:0] hit_slot
);

    logic                 wr_en;
    logic [SLOT_W-1:0]    wr_idx;
    slot_cfg_t            wr_cfg;
    logic [NUM_SLOTS-1:0] match;

    dbg_cfg_parser #(.NUM_SLOTS(NUM_SLOTS)) u_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_byte  (cfg_byte),
        .cfg_valid (cfg_valid),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_cfg    (wr_cfg)
    );

    dbg_slot_bank #(.NUM_SLOTS(NUM_SLOTS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_cfg    (wr_cfg),
        .dec_valid (dec_valid),
        .dec_pc    (dec_pc),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .match     (match)
    );

    dbg_prio_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
        .match (match),
        .any   (hit),
        .idx   (hit_slot)
    );

endmodule

// File: rtl/dbg_match_chk.sv
// Module: dbg_match_chk
// Assertion checker bound to dbg_match_unit; observes ports only.
module dbg_match_chk #(
    parameter int NUM_SLOTS = 4,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_valid,
    input logic              dec_valid,
    input logic [31:0]       dec_pc,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [31:0]       mem_addr,
    input logic              hit,
    input logic [SLOT_W-1:0] hit_slot
);

    // R1: no hit means the slot output rests at 0.
    a_r1_idle_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> hit_slot == '0);

    // R5/R6: a halt request needs a decode or a data access in that cycle.
    a_r6_hit_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (dec_valid || mem_rd || mem_wr));

    // R9: the reported slot exists.
    a_r9_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> int'(hit_slot) < NUM_SLOTS);

    // R3: slot state changes only through accepted configuration bytes.
    a_r3_cfg_only_path: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(dec_valid) && $stable(dec_pc) && $stable(mem_rd) &&
         $stable(mem_wr) && $stable(mem_addr) && !$past(cfg_valid))
        |-> ($stable(hit) && $stable(hit_slot)));

    // R10: outputs are never unknown once out of reset.
    a_r10_known_out: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({hit, hit_slot}));

endmodule

bind dbg_match_unit dbg_match_chk #(.NUM_SLOTS(NUM_SLOTS)) u_dbg_match_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_valid (cfg_valid),
    .dec_valid (dec_valid),
    .dec_pc    (dec_pc),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .hit       (hit),
    .hit_slot  (hit_slot)
);

// File: tb/dbg_match_unit_bench.sv
// Bench for dbg_match_unit: vector table walk, then directed corner tests.
module dbg_match_unit_bench;

    localparam int NS = 4;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    cfg_byte = '0;
    logic          cfg_valid = 1'b0;
    logic          dec_valid = 1'b0;
    logic [31:0]   dec_pc = '0;
    logic          mem_rd = 1'b0;
    logic          mem_wr = 1'b0;
    logic [31:0]   mem_addr = '0;
    logic          hit;
    logic [SW-1:0] hit_slot;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dbg_match_unit #(.NUM_SLOTS(NS)) u_dbg_match_unit (
        .clk(clk), .rst_n(rst_n), .cfg_byte(cfg_byte), .cfg_valid(cfg_valid),
        .dec_valid(dec_valid), .dec_pc(dec_pc), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .hit(hit), .hit_slot(hit_slot)
    );

    // Vector: {dec_valid, dec_pc, mem_rd, mem_wr, mem_addr, exp_hit, exp_slot}
    localparam int NV = 12;
    localparam logic [69:0] VEC [NV] = '{
        {1'b1, 32'h0000_1000, 1'b0, 1'b0, 32'h0,         1'b1, 2'd0}, // R5 break hit
        {1'b1, 32'h0000_1004, 1'b0, 1'b0, 32'h0,         1'b0, 2'd0}, // R5 other PC
        {1'b0, 32'h0,         1'b0, 1'b1, 32'h0000_2000, 1'b1, 2'd1}, // R6 write filter
        {1'b0, 32'h0,         1'b1, 1'b0, 32'h0000_2000, 1'b1, 2'd2}, // R6 read filter
        {1'b0, 32'h0,         1'b1, 1'b0, 32'h0000_3000, 1'b1, 2'd3}, // R6 any, read
        {1'b0, 32'h0,         1'b0, 1'b1, 32'h0000_3000, 1'b1, 2'd3}, // R6 any, write
        {1'b0, 32'h0,         1'b1, 1'b0, 32'h0000_1000, 1'b0, 2'd0}, // R5 data ignores break
        {1'b1, 32'h0000_2000, 1'b0, 1'b0, 32'h0,         1'b0, 2'd0}, // R6 PC ignores watch
        {1'b0, 32'h0,         1'b1, 1'b1, 32'h0000_2000, 1'b1, 2'd1}, // R9 slots 1,2
        {1'b1, 32'h0000_1000, 1'b0, 1'b1, 32'h0000_3000, 1'b1, 2'd0}, // R9 slots 0,3
        {1'b0, 32'h0,         1'b0, 1'b1, 32'h0000_2001, 1'b0, 2'd0}, // R6 exact address
        {1'b0, 32'h0,         1'b0, 1'b0, 32'h0,         1'b0, 2'd0}  // R1 idle
    };
    localparam int TAG [NV] = '{5, 5, 6, 6, 6, 6, 5, 6, 9, 9, 6, 1};

    // Compare one observed pair against expectation and count the result.
    task automatic check(input string req, input logic eh, input logic [SW-1:0] es);
        checks++;
        if (hit !== eh || (eh && hit_slot !== es) || (!eh && hit_slot !== '0)) begin
            errors++;
            $display("FAIL %s: hit=%0b slot=%0d expected hit=%0b slot=%0d",
                     req, hit, hit_slot, eh, es);
        end
    endtask

    // Present one configuration byte for one clock.
    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        cfg_byte  = b;
        cfg_valid = 1'b1;
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    // Program an armed slot: control byte then address, high byte first.
    task automatic program_slot(input logic [3:0] idx, input logic watch,
                                input logic [1:0] acc, input logic [31:0] a);
        send_byte({acc, 1'b1, watch, idx});
        send_byte(a[31:24]);
        send_byte(a[23:16]);
        send_byte(a[15:8]);
        send_byte(a[7:0]);
    endtask

    task automatic drive(input logic dv, input logic [31:0] pc, input logic rd,
                         input logic wr, input logic [31:0] ma);
        dec_valid = dv; dec_pc = pc; mem_rd = rd; mem_wr = wr; mem_addr = ma;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, address zero on both paths
        drive(1'b1, 32'h0, 1'b1, 1'b1, 32'h0);
        check("R1", 1'b0, '0);
        drive(1'b0, 32'h0, 1'b0, 1'b0, 32'h0);

        // R2: build slots from packed control bytes
        program_slot(4'd0, 1'b0, 2'b00, 32'h0000_1000);
        program_slot(4'd1, 1'b1, 2'b00, 32'h0000_2000);
        program_slot(4'd2, 1'b1, 2'b01, 32'h0000_2000);
        program_slot(4'd3, 1'b1, 2'b11, 32'h0000_3000);
        drive(1'b1, 32'h0000_1000, 1'b0, 1'b0, 32'h0);
        check("R2", 1'b1, 2'd0);

        // R10: table walk, outputs sampled in the same cycle as the inputs
        for (int v = 0; v < NV; v++) begin
            drive(VEC[v][69], VEC[v][68:37], VEC[v][36], VEC[v][35], VEC[v][34:3]);
            check($sformatf("R%0d vec%0d", TAG[v], v), VEC[v][2], VEC[v][1:0]);
        end

        // R7: access filter 10 disables a watchpoint
        program_slot(4'd3, 1'b1, 2'b10, 32'h0000_3000);
        drive(1'b0, 32'h0, 1'b1, 1'b1, 32'h0000_3000);
        check("R7", 1'b0, '0);

        // R4: disable byte clears slot 0
        drive(1'b0, 32'h0, 1'b0, 1'b0, 32'h0);
        send_byte(8'h00);
        drive(1'b1, 32'h0000_1000, 1'b0, 1'b0, 32'h0);
        check("R4", 1'b0, '0);

        // R8: out-of-range slot, enable set; its address bytes are consumed
        drive(1'b0, 32'h0, 1'b0, 1'b0, 32'h0);
        program_slot(4'd5, 1'b0, 2'b00, 32'h0000_4000);
        drive(1'b1, 32'h0000_4000, 1'b0, 1'b0, 32'h0);
        check("R8 ignored", 1'b0, '0);
        program_slot(4'd2, 1'b0, 2'b00, 32'h0000_5000);
        drive(1'b1, 32'h0000_5000, 1'b0, 1'b0, 32'h0);
        check("R8 resync", 1'b1, 2'd2);

        // R8: out-of-range disable byte leaves slot 2 armed
        send_byte(8'h0F);
        drive(1'b1, 32'h0000_5000, 1'b0, 1'b0, 32'h0);
        check("R8 disable", 1'b1, 2'd2);

        // R3: partial address with idle gaps keeps the old setting
        send_byte({2'b00, 1'b1, 1'b0, 4'd0});
        send_byte(8'h00);
        @(negedge clk);
        send_byte(8'h00);
        @(negedge clk);
        send_byte(8'h60);
        drive(1'b1, 32'h0000_6000, 1'b0, 1'b0, 32'h0);
        check("R3 partial", 1'b0, '0);
        send_byte(8'h00);
        drive(1'b1, 32'h0000_6000, 1'b0, 1'b0, 32'h0);
        check("R3 complete", 1'b1, 2'd0);

        // R9: slot 0 and slot 2 both break-match; slot 0 reported
        program_slot(4'd2, 1'b0, 2'b00, 32'h0000_6000);
        drive(1'b1, 32'h0000_6000, 1'b0, 1'b0, 32'h0);
        check("R9 tie", 1'b1, 2'd0);

        // R1: a second reset clears everything again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 32'h0000_6000, 1'b1, 1'b1, 32'h0000_2000);
        check("R1 rereset", 1'b0, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule